// File: doc/BRIEF.md
# I2C Message Transfer Sequencer

This block walks a list of I2C messages and turns each one into a string of operations for a byte-level master engine that sits below it. A host loads a message count and pulses `start`. The sequencer then fetches one descriptor per message by index. Each descriptor gives the target address, the direction, whether the address is 10-bit, whether the message continues the previous one without a repeated start, and a byte count. The sequencer opens the bus, forms and sends the address bytes, moves the data in pieces that fit a 64-entry FIFO, and closes the bus with STOP.

Only one operation is outstanding at a time. Every operation is a single-cycle issue pulse followed by a wait for the engine's completion pulse, which carries the acknowledge status. A negative acknowledge, or a wait that runs past the configured limit, sends the sequencer straight to STOP. When STOP completes, it reports a done pulse with the count of messages that finished and an error code.

Top module: `i2c_msg_seq`

## Requirements
- R1: The first operation of a run is START (code 0). Each later message opens with RESTART (code 1) followed by its address phase. A later message with the no-start flag set skips both and goes directly to data. The no-start flag has no effect on the first message.
- R2: For a 7-bit target, the sequencer sends a single address operation (code 3) whose byte is the address in bits [7:1] and the read flag in bit 0.
- R3: For a 10-bit write, the sequencer sends two address operations. The first byte is 11110, then address bits [9:8], then 0. The second byte is address bits [7:0].
- R4: For a 10-bit read, the two bytes of R3 are followed by RESTART and then the first byte again with bit 0 set to 1.
- R5: Write data goes out as write operations (code 4) of at most FIFO_DEPTH (64) bytes each. Every chunk is full except the last, and `op_len` carries the chunk size.
- R6: Read data is fetched with read operations (code 5) of at most 64 bytes each. `op_nak_last` is 1 only on the burst that holds the final remaining bytes of the message.
- R7: A completion pulse with `op_nak` high aborts the run. The sequencer issues STOP (code 2) next. The error is 1 if the refused operation was an address byte and 2 otherwise. `txf_flush` pulses for one cycle, in the cycle after the refusal.
- R8: A completion pulse is accepted in any of the first TIMEOUT_CYC cycles after an issue. If no completion pulse arrives by then, the sequencer issues STOP and reports error 3. A completion pulse that lands in the last allowed cycle is still accepted, and its NAK status decides the outcome.
- R9: After the STOP reply, `done` pulses for one cycle. In that same cycle, `done_count` holds the number of messages fully transferred and `done_err` holds the error code, which is 0 on success.
- R10: `op_valid` is never high in two consecutive cycles.
- R11: After reset, `busy`, `op_valid`, `done` and `txf_flush` are low. A `start` pulse while `busy` is high has no effect on the running sequence.
- R12: A run with zero messages produces START and then STOP. A message with zero length produces its address phase and no data operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| num_msgs | input | IDX_W | Number of messages in the run |
| busy | output | 1 | Run in progress |
| msg_idx | output | IDX_W | Index of the descriptor being fetched |
| msg_addr | input | 10 | Target address of the indexed message |
| msg_rd | input | 1 | Message reads from the target |
| msg_ten | input | 1 | Target uses a 10-bit address |
| msg_nostart | input | 1 | Continue without repeated start or address |
| msg_len | input | LEN_W | Byte count of the message |
| op_valid | output | 1 | One-cycle operation issue |
| op_code | output | 3 | 0 START, 1 RESTART, 2 STOP, 3 address byte, 4 write chunk, 5 read burst |
| op_byte | output | 8 | Address byte for code 3 |
| op_len | output | 7 | Byte count for codes 4 and 5 |
| op_nak_last | output | 1 | Refuse the last byte of this read burst |
| op_done | input | 1 | Engine completion pulse |
| op_nak | input | 1 | Target refused during the completed operation |
| txf_flush | output | 1 | Discard transmit FIFO contents |
| done | output | 1 | Run finished |
| done_count | output | IDX_W | Messages completed |
| done_err | output | 2 | 0 ok, 1 address NAK, 2 data NAK, 3 timeout |

## Verification
The delicate overlap is an engine reply that arrives in the same cycle as the wait timer's final allowed count. The bench provokes it by delaying the address-byte reply by exactly TIMEOUT_CYC cycles, once with an acknowledge and once with a refusal. The first run must complete with no error. The second must end with error 1, exactly one flush pulse, and no timeout code. A further run withholds the reply entirely to show that the limit does trip, with error 3 and no flush.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_STOP    = 3'd2,
    OP_ADDR    = 3'd3,
    OP_WRITE   = 3'd4,
    OP_READ    = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_ADDR_NAK = 2'd1,
    ERR_DATA_NAK = 2'd2,
    ERR_TIMEOUT  = 2'd3
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_BEGIN,
    S_LOAD,
    S_REST,
    S_AHI,
    S_ALO,
    S_ARS,
    S_AHR,
    S_A7,
    S_DATA,
    S_WAIT,
    S_STOP,
    S_SWAIT
  } st_e;

endpackage

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr (
  input  logic [9:0] addr,
  input  logic       rd,
  output logic [7:0] byte7,
  output logic [7:0] hi_wr,
  output logic [7:0] hi_rd,
  output logic [7:0] lo
);
  // 10-bit header: fixed 11110 prefix, two upper address bits, direction
  assign byte7 = {addr[6:0], rd};
  assign hi_wr = {5'b11110, addr[9:8], 1'b0};
  assign hi_rd = {5'b11110, addr[9:8], 1'b1};
  assign lo    = addr[7:0];
endmodule

// File: rtl/i2c_seq_chunk.sv
module i2c_seq_chunk #(
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int CHUNK_W    = 7
) (
  input  logic [LEN_W-1:0]   rem,
  output logic [CHUNK_W-1:0] chunk,
  output logic [LEN_W-1:0]   rem_after,
  output logic               is_final
);
  assign is_final  = (rem <= LEN_W'(FIFO_DEPTH));
  assign chunk     = is_final ? rem[CHUNK_W-1:0] : CHUNK_W'(FIFO_DEPTH);
  assign rem_after = rem - LEN_W'(chunk);
endmodule

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int LIMIT = 1000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (run && !expire) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int IDX_W       = 4,
  parameter int FIFO_DEPTH  = 64,
  parameter int TIMEOUT_CYC = 1000,
  localparam int CHUNK_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   num_msgs,
  output logic               busy,
  output logic [IDX_W-1:0]   msg_idx,
  input  logic [9:0]         msg_addr,
  input  logic               msg_rd,
  input  logic               msg_ten,
  input  logic               msg_nostart,
  input  logic [LEN_W-1:0]   msg_len,
  output logic               op_valid,
  output logic [2:0]         op_code,
  output logic [7:0]         op_byte,
  output logic [CHUNK_W-1:0] op_len,
  output logic               op_nak_last,
  input  logic               op_done,
  input  logic               op_nak,
  output logic               txf_flush,
  output logic               done,
  output logic [IDX_W-1:0]   done_count,
  output logic [1:0]         done_err
);

  // reset: asserted asynchronously, released through two flops
  logic rs_meta_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rst_sn    <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rst_sn    <= rs_meta_q;
    end
  end

  st_e              st_q, st_d, ret_q, ret_d;
  op_e              opc_q, opc_d, op_c;
  err_e             err_q, err_d;
  logic [IDX_W-1:0] idx_q, idx_d, num_q, num_d;
  logic [9:0]       addr_q, addr_d;
  logic             rd_q, rd_d, ten_q, ten_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             tmr_run, tmr_exp, fin, nak_seen;
  logic             flush_q, done_q;
  logic [IDX_W-1:0] dcount_q;
  err_e             derr_q, fin_err;

  logic [7:0]         b7, b_hi_wr, b_hi_rd, b_lo;
  logic [CHUNK_W-1:0] chunk;
  logic [LEN_W-1:0]   rem_after;
  logic               is_final;

  i2c_seq_addr u_addr (
    .addr (addr_q), .rd (rd_q),
    .byte7(b7), .hi_wr(b_hi_wr), .hi_rd(b_hi_rd), .lo(b_lo)
  );

  i2c_seq_chunk #(.LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH), .CHUNK_W(CHUNK_W)) u_chunk (
    .rem(rem_q), .chunk(chunk), .rem_after(rem_after), .is_final(is_final)
  );

  i2c_seq_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_sn), .clr(op_valid), .run(tmr_run), .expire(tmr_exp)
  );

  // next-state logic
  always_comb begin
    st_d        = st_q;
    ret_d       = ret_q;
    opc_d       = opc_q;
    err_d       = err_q;
    idx_d       = idx_q;
    num_d       = num_q;
    addr_d      = addr_q;
    rd_d        = rd_q;
    ten_d       = ten_q;
    rem_d       = rem_q;
    op_valid    = 1'b0;
    op_c        = OP_START;
    op_byte     = '0;
    op_len      = '0;
    op_nak_last = 1'b0;
    tmr_run     = 1'b0;
    fin         = 1'b0;
    nak_seen    = 1'b0;

    unique case (st_q)
      S_IDLE: if (start) begin
        num_d = num_msgs;
        idx_d = '0;
        err_d = ERR_NONE;
        st_d  = S_BEGIN;
      end
      S_BEGIN: begin
        op_valid = 1'b1; op_c = OP_START;
        ret_d = S_LOAD; st_d = S_WAIT;
      end
      S_LOAD: begin
        if (idx_q == num_q) st_d = S_STOP;
        else begin
          addr_d = msg_addr;
          rd_d   = msg_rd;
          ten_d  = msg_ten;
          rem_d  = msg_len;
          if (idx_q != '0 && msg_nostart) st_d = S_DATA;
          else if (idx_q != '0)          st_d = S_REST;
          else                           st_d = msg_ten ? S_AHI : S_A7;
        end
      end
      S_REST: begin
        op_valid = 1'b1; op_c = OP_RESTART;
        ret_d = ten_q ? S_AHI : S_A7; st_d = S_WAIT;
      end
      S_AHI: begin
        op_valid = 1'b1; op_c = OP_ADDR; op_byte = b_hi_wr;
        ret_d = S_ALO; st_d = S_WAIT;
      end
      S_ALO: begin
        op_valid = 1'b1; op_c = OP_ADDR; op_byte = b_lo;
        ret_d = rd_q ? S_ARS : S_DATA; st_d = S_WAIT;
      end
      S_ARS: begin
        op_valid = 1'b1; op_c = OP_RESTART;
        ret_d = S_AHR; st_d = S_WAIT;
      end
      S_AHR: begin
        op_valid = 1'b1; op_c = OP_ADDR; op_byte = b_hi_rd;
        ret_d = S_DATA; st_d = S_WAIT;
      end
      S_A7: begin
        op_valid = 1'b1; op_c = OP_ADDR; op_byte = b7;
        ret_d = S_DATA; st_d = S_WAIT;
      end
      S_DATA: begin
        if (rem_q == '0) begin
          idx_d = idx_q + IDX_W'(1);
          st_d  = S_LOAD;
        end else begin
          op_valid    = 1'b1;
          op_c        = rd_q ? OP_READ : OP_WRITE;
          op_len      = chunk;
          op_nak_last = rd_q && is_final;
          rem_d       = rem_after;
          ret_d       = S_DATA;
          st_d        = S_WAIT;
        end
      end
      S_WAIT: begin
        tmr_run = 1'b1;
        if (op_done) begin
          if (op_nak) begin
            nak_seen = 1'b1;
            err_d    = (opc_q == OP_ADDR) ? ERR_ADDR_NAK : ERR_DATA_NAK;
            st_d     = S_STOP;
          end else begin
            st_d = ret_q;
          end
        end else if (tmr_exp) begin
          err_d = ERR_TIMEOUT;
          st_d  = S_STOP;
        end
      end
      S_STOP: begin
        op_valid = 1'b1; op_c = OP_STOP;
        st_d = S_SWAIT;
      end
      S_SWAIT: begin
        tmr_run = 1'b1;
        if (op_done || tmr_exp) begin
          fin  = 1'b1;
          st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase

    if (op_valid) opc_d = op_c;
  end

  assign fin_err = (err_q == ERR_NONE && !op_done && tmr_exp) ? ERR_TIMEOUT : err_q;

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q     <= S_IDLE;
      ret_q    <= S_IDLE;
      opc_q    <= OP_START;
      err_q    <= ERR_NONE;
      idx_q    <= '0;
      num_q    <= '0;
      addr_q   <= '0;
      rd_q     <= 1'b0;
      ten_q    <= 1'b0;
      rem_q    <= '0;
      flush_q  <= 1'b0;
      done_q   <= 1'b0;
      dcount_q <= '0;
      derr_q   <= ERR_NONE;
    end else begin
      st_q    <= st_d;
      ret_q   <= ret_d;
      opc_q   <= opc_d;
      err_q   <= err_d;
      idx_q   <= idx_d;
      num_q   <= num_d;
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      ten_q   <= ten_d;
      rem_q   <= rem_d;
      flush_q <= nak_seen;
      done_q  <= fin;
      if (fin) begin
        dcount_q <= idx_q;
        derr_q   <= fin_err;
      end
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign msg_idx    = idx_q;
  assign op_code    = op_c;
  assign txf_flush  = flush_q;
  assign done       = done_q;
  assign done_count = dcount_q;
  assign done_err   = derr_q;

endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk #(
  parameter int FIFO_DEPTH  = 64,
  parameter int TIMEOUT_CYC = 1000,
  localparam int CHUNK_W = $clog2(FIFO_DEPTH + 1),
  localparam int GW      = $clog2(TIMEOUT_CYC + 8) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               op_valid,
  input logic [2:0]         op_code,
  input logic [CHUNK_W-1:0] op_len,
  input logic               op_nak_last,
  input logic               op_done,
  input logic               op_nak,
  input logic               txf_flush,
  input logic               done
);
  // cycles since the last issue while a run is active (saturating)
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= '0;
    else if (op_valid || !busy)     gap_q <= '0;
    else if (gap_q != {GW{1'b1}})   gap_q <= gap_q + GW'(1);
  end

  a_r10_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  a_r1_opens_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (op_valid && op_code == 3'd0));

  a_r6_nak_last_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_nak_last) |-> (op_code == 3'd5));

  a_r5_chunk_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 3'd4 || op_code == 3'd5)) |->
      (op_len != '0 && op_len <= CHUNK_W'(FIFO_DEPTH)));

  a_r7_flush_follows_nak: assert property (@(posedge clk) disable iff (!rst_n)
    txf_flush |-> $past(op_done && op_nak));

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (gap_q <= GW'(TIMEOUT_CYC + 2)));
endmodule

bind i2c_msg_seq i2c_msg_seq_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (.*);

// File: tb/i2c_msg_seq_tb.sv
`timescale 1ns/1ps
module i2c_msg_seq_tb;
  localparam int LW  = 16;
  localparam int IW  = 4;
  localparam int FD  = 64;
  localparam int TMO = 16;
  localparam int CW  = $clog2(FD + 1);

  typedef struct packed {
    logic [9:0]  a;
    logic        rd;
    logic        ten;
    logic        ns;
    logic [15:0] len;
  } desc_t;

  typedef struct packed {
    logic [1:0] n;
    desc_t      d0;
    desc_t      d1;
    desc_t      d2;
    logic [7:0] nak_at;
    logic [7:0] slow_at;
    logic [7:0] slow_d;
    logic [1:0] ecnt;
    logic [1:0] eerr;
  } vec_t;

  localparam desc_t NO = '{10'h000, 1'b0, 1'b0, 1'b0, 16'd0};
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd1, '{10'h050,1'b0,1'b0,1'b0,16'd2},   NO, NO, 8'hFF, 8'hFF, 8'd0,  2'd1, 2'd0},
    '{2'd2, '{10'h050,1'b0,1'b0,1'b0,16'd1},   '{10'h050,1'b1,1'b0,1'b0,16'd3}, NO, 8'hFF, 8'hFF, 8'd0, 2'd2, 2'd0},
    '{2'd1, '{10'h2A5,1'b0,1'b1,1'b0,16'd1},   NO, NO, 8'hFF, 8'hFF, 8'd0,  2'd1, 2'd0},
    '{2'd1, '{10'h1C3,1'b1,1'b1,1'b0,16'd2},   NO, NO, 8'hFF, 8'hFF, 8'd0,  2'd1, 2'd0},
    '{2'd2, '{10'h011,1'b0,1'b0,1'b0,16'd130}, '{10'h011,1'b1,1'b0,1'b0,16'd128}, NO, 8'hFF, 8'hFF, 8'd0, 2'd2, 2'd0},
    '{2'd2, '{10'h07F,1'b1,1'b0,1'b0,16'd65},  '{10'h07F,1'b1,1'b0,1'b0,16'd64}, NO, 8'hFF, 8'hFF, 8'd0, 2'd2, 2'd0},
    '{2'd2, '{10'h020,1'b0,1'b0,1'b0,16'd1},   '{10'h020,1'b0,1'b0,1'b1,16'd3}, NO, 8'hFF, 8'hFF, 8'd0, 2'd2, 2'd0},
    '{2'd1, '{10'h033,1'b0,1'b0,1'b0,16'd2},   NO, NO, 8'd1,  8'hFF, 8'd0,  2'd0, 2'd1},
    '{2'd1, '{10'h033,1'b0,1'b0,1'b0,16'd100}, NO, NO, 8'd3,  8'hFF, 8'd0,  2'd0, 2'd2},
    '{2'd1, '{10'h033,1'b0,1'b0,1'b0,16'd5},   NO, NO, 8'hFF, 8'd2,  8'd0,  2'd0, 2'd3},
    '{2'd1, '{10'h033,1'b0,1'b0,1'b0,16'd5},   NO, NO, 8'hFF, 8'd1,  8'd16, 2'd1, 2'd0},
    '{2'd1, '{10'h033,1'b0,1'b0,1'b0,16'd5},   NO, NO, 8'd1,  8'd1,  8'd16, 2'd0, 2'd1},
    '{2'd0, NO, NO, NO, 8'hFF, 8'hFF, 8'd0, 2'd0, 2'd0},
    '{2'd3, '{10'h050,1'b0,1'b0,1'b0,16'd1},   '{10'h1C3,1'b1,1'b1,1'b0,16'd2}, '{10'h050,1'b0,1'b0,1'b0,16'd1}, 8'd7, 8'hFF, 8'd0, 2'd1, 2'd1},
    '{2'd1, '{10'h033,1'b0,1'b0,1'b0,16'd0},   NO, NO, 8'hFF, 8'hFF, 8'd0,  2'd1, 2'd0}
  };

  logic clk, rst_n, start;
  logic [IW-1:0] num_msgs, msg_idx, done_count;
  logic busy, msg_rd, msg_ten, msg_nostart;
  logic [9:0] msg_addr;
  logic [LW-1:0] msg_len;
  logic op_valid, op_nak_last, op_done, op_nak, txf_flush, done;
  logic [2:0] op_code;
  logic [7:0] op_byte;
  logic [CW-1:0] op_len;
  logic [1:0] done_err;

  i2c_msg_seq #(.LEN_W(LW), .IDX_W(IW), .FIFO_DEPTH(FD), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_msgs(num_msgs), .busy(busy),
    .msg_idx(msg_idx), .msg_addr(msg_addr), .msg_rd(msg_rd), .msg_ten(msg_ten),
    .msg_nostart(msg_nostart), .msg_len(msg_len), .op_valid(op_valid),
    .op_code(op_code), .op_byte(op_byte), .op_len(op_len), .op_nak_last(op_nak_last),
    .op_done(op_done), .op_nak(op_nak), .txf_flush(txf_flush), .done(done),
    .done_count(done_count), .done_err(done_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  vec_t cv;

  function automatic desc_t pick(input vec_t v, input int i);
    case (i)
      0:       return v.d0;
      1:       return v.d1;
      default: return v.d2;
    endcase
  endfunction

  desc_t cur_d;
  always_comb cur_d = pick(cv, int'(msg_idx));
  assign msg_addr    = cur_d.a;
  assign msg_rd      = cur_d.rd;
  assign msg_ten     = cur_d.ten;
  assign msg_nostart = cur_d.ns;
  assign msg_len     = cur_d.len;

  // engine model and output log
  int log_n, done_n, flush_n, dbl_issue;
  int log_c [32], log_b [32], log_l [32], log_nl [32];
  int got_cnt, got_err;
  logic pend, pnak, prev_valid;
  int pcnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      op_done = 1'b0; op_nak = 1'b0; pend = 1'b0; prev_valid = 1'b0;
    end else begin
      op_done = 1'b0; op_nak = 1'b0;
      if (pend) begin
        if (pcnt <= 1) begin op_done = 1'b1; op_nak = pnak; pend = 1'b0; end
        else pcnt = pcnt - 1;
      end
      if (op_valid && prev_valid) dbl_issue++;
      prev_valid = op_valid;
      if (op_valid) begin
        int k, d;
        k = log_n;
        if (k < 32) begin
          log_c[k] = int'(op_code); log_b[k] = int'(op_byte);
          log_l[k] = int'(op_len);  log_nl[k] = int'(op_nak_last);
        end
        log_n++;
        pnak = (k == int'(cv.nak_at));
        d = (k == int'(cv.slow_at)) ? int'(cv.slow_d) : 1;
        pend = (d != 0);
        pcnt = d;
      end
      if (txf_flush) flush_n++;
      if (done) begin done_n++; got_cnt = int'(done_count); got_err = int'(done_err); end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference op list from the requirements
  int exp_n;
  int exp_c [32], exp_b [32], exp_l [32], exp_nl [32];

  task automatic push(input int c, input int b, input int l, input int nl);
    exp_c[exp_n] = c; exp_b[exp_n] = b; exp_l[exp_n] = l; exp_nl[exp_n] = nl;
    exp_n++;
  endtask

  task automatic build_exp(input vec_t v);
    int f;
    exp_n = 0;
    push(0, 0, 0, 0);
    for (int i = 0; i < int'(v.n); i++) begin
      desc_t d;
      int rem, c;
      d = pick(v, i);
      if (i > 0 && !d.ns) push(1, 0, 0, 0);
      if (i == 0 || !d.ns) begin
        if (d.ten) begin
          push(3, int'({5'b11110, d.a[9:8], 1'b0}), 0, 0);
          push(3, int'(d.a[7:0]), 0, 0);
          if (d.rd) begin
            push(1, 0, 0, 0);
            push(3, int'({5'b11110, d.a[9:8], 1'b1}), 0, 0);
          end
        end else push(3, int'({d.a[6:0], d.rd}), 0, 0);
      end
      rem = int'(d.len);
      while (rem > 0) begin
        c = (rem > FD) ? FD : rem;
        push(d.rd ? 5 : 4, 0, c, (d.rd && rem <= FD) ? 1 : 0);
        rem -= c;
      end
    end
    f = int'(v.nak_at);
    if (int'(v.slow_at) < f && (v.slow_d == 0 || int'(v.slow_d) > TMO)) f = int'(v.slow_at);
    if (f < exp_n) exp_n = f + 1;
    push(2, 0, 0, 0);
  endtask

  function automatic string tag_of(input int s);
    case (s)
      0: return "R2";  1: return "R1";  2: return "R3";  3: return "R4";
      4: return "R5";  5: return "R6";  6: return "R1";  7: return "R7";
      8: return "R7";  9: return "R8";  10: return "R8"; 11: return "R8";
      12: return "R12"; 13: return "R7"; default: return "R12";
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input int s, input int extra_at);
    int w;
    cv = v; num_msgs = IW'(v.n);
    log_n = 0; done_n = 0; flush_n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (extra_at > 0) begin
      repeat (extra_at) @(negedge clk);
      num_msgs = IW'(3); start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    w = 0;
    while (done_n == 0 && w < 4000) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    check(done_n == 1, "R9", $sformatf("vec %0d done pulses", s), done_n, 1);
    build_exp(v);
    check(log_n == exp_n, tag_of(s), $sformatf("vec %0d op count", s), log_n, exp_n);
    for (int j = 0; j < exp_n && j < log_n; j++) begin
      bit ok;
      ok = (log_c[j] == exp_c[j]);
      if (exp_c[j] == 3) ok = ok && (log_b[j] == exp_b[j]);
      if (exp_c[j] >= 4) ok = ok && (log_l[j] == exp_l[j]) && (log_nl[j] == exp_nl[j]);
      check(ok, tag_of(s), $sformatf("vec %0d op %0d code/byte/len/naklast %0d/%0h/%0d/%0d",
            s, j, log_c[j], log_b[j], log_l[j], log_nl[j]),
            log_c[j] * 1000 + log_l[j], exp_c[j] * 1000 + exp_l[j]);
    end
    check(got_cnt == int'(v.ecnt), "R9", $sformatf("vec %0d done_count", s), got_cnt, int'(v.ecnt));
    check(got_err == int'(v.eerr), "R9", $sformatf("vec %0d done_err", s), got_err, int'(v.eerr));
    check(flush_n == ((v.eerr == 2'd1 || v.eerr == 2'd2) ? 1 : 0), "R7",
          $sformatf("vec %0d flush pulses", s), flush_n,
          (v.eerr == 2'd1 || v.eerr == 2'd2) ? 1 : 0);
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; num_msgs = '0; cv = VEC[0];
    dbl_issue = 0; got_cnt = -1; got_err = -1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(!busy && !op_valid && !done && !txf_flush, "R11", "reset outputs idle",
          int'({busy, op_valid, done, txf_flush}), 0);

    for (int s = 0; s < NV; s++) run_vec(VEC[s], s, 0);

    // R11 start while busy is ignored
    run_vec(VEC[0], 0, 3);
    check(log_n == 4, "R11", "second start during run ignored", log_n, 4);

    // R10 no back-to-back issues seen at the ports
    check(dbl_issue == 0, "R10", "consecutive issue cycles", dbl_issue, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule